// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that a microprocessor reads and writes like a memory location. The processor starts a conversion with a write strobe and collects the result with a read strobe. The block also takes a comparator decision and the conversion clock. It drives the trial code onto an external resistor ladder, signals completion on an active-low interrupt, and presents the result on an 8-bit data bus that a pad-level tri-state driver puts onto the shared bus while the output enable is high.

The bus strobes arrive with no fixed relation to the conversion clock, so they are synchronized first. A rising write strobe is captured as a start request. The controller then waits for its internal eight-clock phase to line up, samples, and resolves the eight bits from the most significant bit down. It copies the final code into a separate output latch and pulls the interrupt low. Holding the write strobe low parks the converter. A new start in mid-conversion abandons the work in progress. Connecting the interrupt back to the write input makes the converter run continuously.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, intr_n is 1, data_oe is 0, data_out is 0x00 and trial_code is 0x00.
- R2: With cmp_hi = 1 exactly when the analog level is at or above trial_code, the result read back after a conversion equals the analog level for every level from 0x00 to 0xFF.
- R3: If cmp_hi stays 0 for every trial, the result is 0x00.
- R4: A conversion starts on a rising edge of wr_n while cs_n is low. While cs_n and wr_n are both low, no conversion completes and intr_n does not fall.
- R5: intr_n falls 66 to 73 rising clock edges after the wr_n rise that started the conversion. The exact count depends on the internal eight-clock phase at that moment.
- R6: A falling edge on rd_n or on wr_n while cs_n is low sets intr_n back to 1 within three rising clock edges.
- R7: data_oe is 1 exactly while cs_n and rd_n are both low. It responds combinationally, with no clock delay.
- R8: data_out keeps the previous result for the whole of a later conversion and changes only at the edge where intr_n falls.
- R9: A start request during a conversion abandons that conversion. The abandoned conversion never pulls intr_n low. intr_n falls inside the R5 window counted from the new start, and the result comes from the new conversion.
- R10: With wr_n driven from intr_n and cs_n held low, conversions repeat without further stimulus. The latest result appears on data_out.
- R11: If a clearing strobe edge is detected at the same clock edge on which a conversion completes, intr_n goes to 0.
- R12: wr_n edges while cs_n is high neither start nor hold the converter, and they leave intr_n and the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| wr_n | input | 1 | Active-low write strobe; its rising edge starts a conversion |
| rd_n | input | 1 | Active-low read strobe |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above the trial level |
| trial_code | output | 8 | Code applied to the external ladder |
| intr_n | output | 1 | Active-low conversion-complete interrupt |
| data_out | output | 8 | Latched result for the pad tri-state driver |
| data_oe | output | 1 | Output enable for the pad tri-state driver |

## Verification
Completion of a conversion and a clearing strobe edge can land on the same clock edge. One of them tries to set the interrupt and the other tries to clear it. The bench first measures the latency of one conversion. It then starts a second conversion at the same position of the eight-clock phase counter, so the latency repeats exactly. It drops rd_n so that its synchronized falling edge is detected on the completion edge. The interrupt must then be low and stay low, and a later read must return the new result.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Conversion sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SYNC   = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_CONV   = 3'd3,
        ST_DONE   = 3'd4
    } sar_state_e;

    // Decoded bus strobe events in the conversion-clock domain
    typedef struct packed {
        logic start;   // write strobe rose with chip select low
        logic hold;    // write strobe and chip select both low
        logic clr;     // falling read or write strobe with chip select low
    } strobe_evt_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sar_strobe.sv
module sar_strobe
    import sar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_s,
    input  logic        wr_s,
    input  logic        rd_s,
    output strobe_evt_t evt_o
);

    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d         = q;
        d.wr_prev = wr_s;
        d.rd_prev = rd_s;

        evt_o.start = !cs_s &&  wr_s && !q.wr_prev;
        evt_o.hold  = !cs_s && !wr_s;
        evt_o.clr   = !cs_s && ((q.wr_prev && !wr_s) || (q.rd_prev && !rd_s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{wr_prev: 1'b1, rd_prev: 1'b1};
        else        q <= d;
    end

endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int N          = 8,
    parameter int PH_W       = 3,
    parameter int SAMPLE_CYC = 5,
    parameter int STEP_CYC   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_evt_t  evt_i,
    input  logic         cmp_hi_i,
    output logic [N-1:0] trial_o,
    output logic         done_o
);

    localparam int CNT_MAX = (SAMPLE_CYC > STEP_CYC) ? SAMPLE_CYC : STEP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = (N > 1) ? $clog2(N) : 1;

    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] STEP_LAST   = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] DECIDE_AT   = CNT_W'(1);
    localparam logic [BIT_W-1:0] MSB_IDX     = BIT_W'(N - 1);

    typedef struct packed {
        sar_state_e       st;
        logic [PH_W-1:0]  phase;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bidx;
        logic [N-1:0]     sar;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d       = q;
        d.phase = q.phase + 1'b1;   // free-running internal clock phase

        if (evt_i.hold) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.sar = '0;
        end else if (evt_i.start) begin
            d.st  = ST_SYNC;
            d.cnt = '0;
            d.sar = '0;
        end else begin
            case (q.st)
                ST_IDLE: ;
                ST_SYNC: begin
                    if (q.phase == '1) begin
                        d.st  = ST_SAMPLE;
                        d.cnt = '0;
                    end
                end
                ST_SAMPLE: begin
                    if (q.cnt == SAMPLE_LAST) begin
                        d.st   = ST_CONV;
                        d.cnt  = '0;
                        d.bidx = MSB_IDX;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (q.cnt == '0) begin
                        d.sar[q.bidx] = 1'b1;
                    end
                    if (q.cnt == DECIDE_AT && !cmp_hi_i) begin
                        d.sar[q.bidx] = 1'b0;
                    end
                    if (q.cnt == STEP_LAST) begin
                        d.cnt = '0;
                        if (q.bidx == '0) d.st   = ST_DONE;
                        else              d.bidx = q.bidx - 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DONE: d.st = ST_IDLE;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign trial_o = q.sar;
    // a start or hold on the completing edge abandons the result
    assign done_o  = (q.st == ST_DONE) && !evt_i.hold && !evt_i.start;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sar_pkg::*;
#(
    parameter int N          = 8,
    parameter int PH_W       = 3,
    parameter int SAMPLE_CYC = 5,
    parameter int STEP_CYC   = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic         cmp_hi,
    output logic [N-1:0] trial_code,
    output logic         intr_n,
    output logic [N-1:0] data_out,
    output logic         data_oe
);

    localparam int NUM_STRB = 3;

    logic [NUM_STRB-1:0] strb_s;
    strobe_evt_t         evt;
    logic                done;
    logic                start_evt, hold_evt, clr_evt;

    sar_sync #(
        .W       (NUM_STRB),
        .STAGES  (2),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, wr_n, rd_n}),
        .sync_o  (strb_s)
    );

    sar_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_s  (strb_s[2]),
        .wr_s  (strb_s[1]),
        .rd_s  (strb_s[0]),
        .evt_o (evt)
    );

    sar_engine #(
        .N          (N),
        .PH_W       (PH_W),
        .SAMPLE_CYC (SAMPLE_CYC),
        .STEP_CYC   (STEP_CYC)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .cmp_hi_i (cmp_hi),
        .trial_o  (trial_code),
        .done_o   (done)
    );

    assign start_evt = evt.start;
    assign hold_evt  = evt.hold;
    assign clr_evt   = evt.clr;

    typedef struct packed {
        logic [N-1:0] res;
        logic         intr_n;
    } out_t;

    out_t d, q;

    always_comb begin
        d = q;
        if (done) begin
            d.res    = trial_code;
            d.intr_n = 1'b0;          // completion outranks a clearing edge
        end else if (evt.clr) begin
            d.intr_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{res: '0, intr_n: 1'b1};
        else        q <= d;
    end

    assign intr_n   = q.intr_n;
    assign data_out = q.res;
    assign data_oe  = !cs_n && !rd_n;

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
    parameter int N          = 8,
    parameter int PH_W       = 3,
    parameter int SAMPLE_CYC = 5,
    parameter int STEP_CYC   = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_evt,
    input logic         hold_evt,
    input logic         clr_evt,
    input logic         done,
    input logic         intr_n,
    input logic [N-1:0] data_out
);

    localparam int LAT_LO = SAMPLE_CYC + N * STEP_CYC + 2;
    localparam int LAT_HI = SAMPLE_CYC + N * STEP_CYC + 1 + (2 ** PH_W);
    localparam int LAT_W  = $clog2(LAT_HI + 2);

    logic [LAT_W-1:0] lat_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            seen_q <= 1'b0;
        end else if (start_evt) begin
            lat_q  <= '0;
            seen_q <= 1'b1;
        end else if (lat_q != '1) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R4
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_evt |=> !$fell(intr_n));

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !$fell(intr_n));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !intr_n);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !done) |=> intr_n);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(data_out));

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n) |-> (seen_q && lat_q >= LAT_W'(LAT_LO) && lat_q <= LAT_W'(LAT_HI)));

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(
    .N          (N),
    .PH_W       (PH_W),
    .SAMPLE_CYC (SAMPLE_CYC),
    .STEP_CYC   (STEP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .hold_evt  (hold_evt),
    .clr_evt   (clr_evt),
    .done      (done),
    .intr_n    (intr_n),
    .data_out  (data_out)
);

// File: tb/sar_bus_ctrl_tb_top.sv
module sar_bus_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_drv = 1'b1;
    logic       fr_en = 1'b0;
    logic       rd_n = 1'b1;
    logic [7:0] vin = 8'h00;
    logic       cmp_low = 1'b0;
    logic       wr_pin;
    logic       cmp_hi;
    logic [7:0] trial_code;
    logic       intr_n;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] exp_q[$];
    logic       mon_en = 1'b1;
    logic       mon_busy = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // ladder and comparator model
    assign cmp_hi = cmp_low ? 1'b0 : (vin >= trial_code);
    assign wr_pin = fr_en ? intr_n : wr_drv;

    sar_bus_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_pin),
        .rd_n       (rd_n),
        .cmp_hi     (cmp_hi),
        .trial_code (trial_code),
        .intr_n     (intr_n),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // scoreboard monitor: on each interrupt, read back and compare
    initial begin
        logic       ip;
        logic [7:0] e;
        ip = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && ip && !intr_n && exp_q.size() != 0) begin
                mon_busy = 1'b1;
                e = exp_q.pop_front();
                rd_n = 1'b0;
                @(negedge clk);
                chk("R7 enable during read", int'(data_oe), 1);
                chk("R2/R3 result", int'(data_out), int'(e));
                repeat (3) @(negedge clk);
                chk("R6 read clears interrupt", int'(intr_n), 1);
                rd_n = 1'b1;
                @(negedge clk);
                chk("R7 enable drops after read", int'(data_oe), 0);
                mon_busy = 1'b0;
            end
            ip = intr_n;
        end
    end

    // driver: pushes the expected result and starts a conversion
    task automatic run_conv(input logic [7:0] v, input bit low, input int hold,
                            output int lat, output int c0);
        int bad;
        bad = 0;
        vin = v;
        cmp_low = low;
        exp_q.push_back(low ? 8'h00 : v);
        cs_n = 1'b0;
        wr_drv = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i >= 3 && !intr_n) bad++;
        end
        if (hold > 3) chk("R4 held write keeps converter idle", bad, 0);
        wr_drv = 1'b1;
        c0 = cyc;
        lat = 0;
        while (intr_n && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R5 latency window", int'(lat >= 66 && lat <= 73), 1);
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic strobe_start(input int hold);
        wr_drv = 1'b0;
        repeat (hold) @(negedge clk);
        wr_drv = 1'b1;
    endtask

    task automatic wait_intr(output int lat);
        lat = 0;
        while (intr_n && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n1, c1, lat, c0, falls, stay_hi;
        logic ip;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 intr_n after reset", int'(intr_n), 1);
        chk("R1 data_oe after reset", int'(data_oe), 0);
        chk("R1 data_out after reset", int'(data_out), 0);
        chk("R1 trial_code after reset", int'(trial_code), 0);

        // R4 long hold, then a conversion; keep its latency and phase
        run_conv(8'h3C, 1'b0, 150, n1, c1);

        // R2 code sweep of corner and mid values
        run_conv(8'h00, 1'b0, 2, lat, c0);
        run_conv(8'hFF, 1'b0, 2, lat, c0);
        run_conv(8'h80, 1'b0, 2, lat, c0);
        run_conv(8'h7F, 1'b0, 2, lat, c0);
        run_conv(8'h01, 1'b0, 2, lat, c0);
        run_conv(8'hA5, 1'b0, 2, lat, c0);

        // R3 comparator never high
        run_conv(8'hC8, 1'b1, 2, lat, c0);
        run_conv(8'h6D, 1'b0, 2, lat, c0);

        // R12 write strobes with chip select high are ignored
        mon_en = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R7 no enable with chip select high", int'(data_oe), 0);
        rd_n = 1'b1;
        vin = 8'h12;
        strobe_start(4);
        repeat (100) @(negedge clk);
        chk("R12 interrupt unchanged", int'(intr_n), 1);
        cs_n = 1'b0;
        rd_n = 1'b0;
        @(negedge clk);
        chk("R12 latch unchanged", int'(data_out), 8'h6D);
        rd_n = 1'b1;
        @(negedge clk);

        // R8 previous result readable during a conversion
        vin = 8'h11;
        strobe_start(2);
        wait_intr(lat);
        chk("R2 result 0x11", int'(data_out), 8'h11);
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_n = 1'b1;
        vin = 8'h22;
        strobe_start(2);
        repeat (30) @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R8 old result during conversion", int'(data_out), 8'h11);
        chk("R7 enable during read", int'(data_oe), 1);
        rd_n = 1'b1;
        repeat (10) @(negedge clk);

        // R9 abort and restart
        vin = 8'h33;
        strobe_start(2);
        stay_hi = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!intr_n) stay_hi = 0;
        end
        chk("R9 aborted conversion silent", stay_hi, 1);
        lat = 60;
        while (intr_n && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R9 latency from new start", int'(lat >= 66 && lat <= 73), 1);
        chk("R9 result of new conversion", int'(data_out), 8'h33);

        // R6 write falling edge clears the interrupt
        wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 write clears interrupt", int'(intr_n), 1);

        // R11 clearing edge on the completion edge
        vin = 8'h9E;
        while ((cyc % 8) != (c1 % 8)) @(negedge clk);
        wr_drv = 1'b1;
        repeat (n1 - 3) @(negedge clk);
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 completion outranks clear", int'(intr_n), 0);
        stay_hi = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (intr_n) stay_hi = 1;
        end
        chk("R11 interrupt stays low", stay_hi, 0);
        chk("R11 new result latched", int'(data_out), 8'h9E);
        rd_n = 1'b1;
        @(negedge clk);

        // R10 free-running
        vin = 8'h5A;
        fr_en = 1'b1;
        falls = 0;
        ip = intr_n;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (ip && !intr_n) falls++;
            ip = intr_n;
        end
        chk("R10 repeated conversions", int'(falls >= 5), 1);
        wr_drv = 1'b1;
        fr_en = 1'b0;
        repeat (120) @(negedge clk);
        chk("R10 free-running result", int'(data_out), 8'h5A);

        finish_run();
    end

endmodule